// File: doc/BRIEF.md
# Page Program Sequencer

This block sits behind the serial front-end of a byte-wide nonvolatile memory. When a memory-write command has been decoded, the front-end passes on the start address. It then passes each complete data byte as it arrives. The protect controller supplies the write-enable latch state and a permit flag for the addressed block. The sequencer places the bytes in a page-sized latch. The low offset bits advance with each byte and the page number stays fixed. When chip select closes on a byte boundary, the sequencer runs a timed program cycle. At the end of that cycle it copies only the received locations into the memory array model.

During the program cycle the write-in-progress flag is high. Completion gives a one-clock done pulse and a request to clear the write-enable latch. A supply-fail indication aborts the sequence at any point and also requests the latch clear. The program time is a parameter counted in system clocks, so a simulation can use a short cycle.

The controller has four states:
- `ST_IDLE` waits for a command.
- `ST_COLLECT` fills the latch.
- `ST_PROGRAM` runs the program timer.
- `ST_COMMIT` walks the latch and writes the memory.

It has six transitions:
- ACCEPT goes from IDLE to COLLECT.
- CLOSE_OK goes from COLLECT to PROGRAM.
- CLOSE_BAD goes from COLLECT to IDLE.
- TIMEOUT goes from PROGRAM to COMMIT.
- FINISH goes from COMMIT to IDLE.
- ABORT goes from any state to IDLE when `pwr_fail` is high.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `wip`, `done` and `wel_clr` are low and every memory location reads 8'hFF.
- R2: A command is accepted only when `wel` and `permit` are both high at `cmd_start` and the block is idle. A rejected command, or one that arrives while `wip` is high, changes no memory location and does not raise `wip`.
- R3: Byte k of an accepted frame goes to address {page of `start_addr`, (offset of `start_addr` + k) mod 64}. The offset is the low 6 bits. The page number never changes within a frame.
- R4: When more than 64 bytes arrive, later bytes overwrite earlier ones at the same offset. The byte received last at an offset is the one stored.
- R5: Programming starts only on `cs_rise` with `bit_phase` equal to 0 and at least one byte received. Any other close discards the frame, leaves `wip` low and leaves memory unchanged.
- R6: `wip` goes high on the clock after `cs_rise` is sampled and stays high for exactly PROG_CYCLES + 64 clocks.
- R7: Page locations that received no byte in the frame keep their previous contents.
- R8: `done` and `wel_clr` pulse together for one clock in the last clock of `wip`. Exactly one such pulse occurs per program cycle.
- R9: `pwr_fail` drives `wel_clr` high in the same clock and returns the block to idle on the next clock. A frame aborted before its commit phase changes no memory location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-clock pulse: write command and address decoded |
| start_addr | input | ADDR_W | First byte address of the frame |
| wel | input | 1 | Write-enable latch state from the protect controller |
| permit | input | 1 | High when the addressed block is writable |
| byte_vld | input | 1 | One-clock pulse: a complete data byte is present |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | One-clock pulse: chip select was released |
| bit_phase | input | 3 | Bits received after the last complete byte, at release |
| pwr_fail | input | 1 | Supply-fail indication |
| rd_addr | input | ADDR_W | Read address of the memory model |
| rd_data | output | 8 | Memory contents at `rd_addr` (combinational) |
| wip | output | 1 | Program cycle in progress |
| done | output | 1 | One-clock completion pulse |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The bench sends frames with more than 64 bytes and checks that the last byte wins at each offset. A design that did not wrap the offset inside the page would spill into the next page or lose the late bytes. Frames closed off a byte boundary or with no data must leave `wip` low; an eager sequencer would program garbage there. Commands issued during a running cycle must leave memory untouched, and a supply failure during the timer must leave the page unchanged. The bench also counts the `wip` length exactly, which exposes an off-by-one in the timer or the commit walk. It compares the whole memory after every frame, which exposes stale mask bits from an earlier frame and writes to untouched locations.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef logic [7:0] pgw_byte_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_COMMIT  = 2'd3
    } pgw_state_e;
endpackage

// File: rtl/pgw_page_latch.sv
module pgw_page_latch #(
    parameter int PAGE_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_slot,
    input  pgw_pkg::pgw_byte_t            wr_data,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
    output pgw_pkg::pgw_byte_t            rd_data,
    output logic                          rd_valid,
    output logic                          any_valid
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);

    pgw_pkg::pgw_byte_t    data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(s)) begin
                data_q[s] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
        end
    end

    assign rd_data   = data_q[rd_slot];
    assign rd_valid  = valid_q[rd_slot];
    assign any_valid = |valid_q;

    assert_slot_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_q[$past(wr_slot)]);

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid);
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST);

    assert_expire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/pgw_mem_array.sv
module pgw_mem_array #(
    parameter int          ADDR_W = 10,
    parameter logic [7:0]  ERASED = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  pgw_pkg::pgw_byte_t wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output pgw_pkg::pgw_byte_t rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    pgw_pkg::pgw_byte_t cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= ERASED;
            end
        end else if (we) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/pgw_seq_fsm.sv
module pgw_seq_fsm
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int ADDR_W     = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_start,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic                          wel,
    input  logic                          permit,
    input  logic                          byte_vld,
    input  logic                          cs_rise,
    input  logic [2:0]                    bit_phase,
    input  logic                          pwr_fail,
    input  logic                          tmr_expire,
    input  logic                          any_valid,
    input  logic                          slot_valid,
    output logic                          lat_clear,
    output logic                          lat_wr,
    output logic [$clog2(PAGE_BYTES)-1:0] lat_slot,
    output logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
    output logic                          tmr_run,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          wip,
    output logic                          done,
    output logic                          wel_clr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_SLOT = OFS_W'(PAGE_BYTES - 1);

    pgw_state_e       state_q, state_d;
    logic [PG_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] cidx_q;
    logic             accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start && wel && permit) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (cs_rise) begin
                    if (bit_phase == 3'd0 && (any_valid || byte_vld)) state_d = ST_PROGRAM;
                    else                                              state_d = ST_IDLE;
                end
            end
            ST_PROGRAM: begin
                if (tmr_expire) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (cidx_q == LAST_SLOT) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (pwr_fail) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == ST_IDLE) && (state_d == ST_COLLECT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            cidx_q <= '0;
        end else begin
            if (accept) begin
                page_q <= start_addr[ADDR_W-1:OFS_W];
                ofs_q  <= start_addr[OFS_W-1:0];
            end else if (lat_wr) begin
                ofs_q  <= ofs_q + 1'b1;
            end
            if (state_q == ST_COMMIT) cidx_q <= cidx_q + 1'b1;
            else                      cidx_q <= '0;
        end
    end

    always_comb begin
        lat_clear = accept;
        lat_wr    = (state_q == ST_COLLECT) && byte_vld && !pwr_fail;
        lat_slot  = ofs_q;
        rd_slot   = cidx_q;
        tmr_run   = (state_q == ST_PROGRAM);
        mem_we    = (state_q == ST_COMMIT) && slot_valid && !pwr_fail;
        mem_addr  = {page_q, cidx_q};
        wip       = (state_q == ST_PROGRAM) || (state_q == ST_COMMIT);
        done      = (state_q == ST_COMMIT) && (cidx_q == LAST_SLOT) && !pwr_fail;
        wel_clr   = done || pwr_fail;
    end

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> state_q == ST_IDLE);

    assert_start_on_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise && bit_phase == 3'd0));

    assert_done_ends_wip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wip);
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
    parameter int PAGE_BYTES  = 64,
    parameter int ADDR_W      = 10,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wel,
    input  logic              permit,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic [2:0]        bit_phase,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              wip,
    output logic              done,
    output logic              wel_clr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic             lat_clear, lat_wr, lat_rd_valid, any_valid;
    logic [OFS_W-1:0] lat_slot, rd_slot;
    logic [7:0]       lat_rd_data;
    logic             tmr_run, tmr_expire;
    logic             mem_we;
    logic [ADDR_W-1:0] mem_addr;

    pgw_seq_fsm #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .start_addr(start_addr),
        .wel(wel), .permit(permit),
        .byte_vld(byte_vld), .cs_rise(cs_rise), .bit_phase(bit_phase),
        .pwr_fail(pwr_fail), .tmr_expire(tmr_expire),
        .any_valid(any_valid), .slot_valid(lat_rd_valid),
        .lat_clear(lat_clear), .lat_wr(lat_wr), .lat_slot(lat_slot),
        .rd_slot(rd_slot), .tmr_run(tmr_run),
        .mem_we(mem_we), .mem_addr(mem_addr),
        .wip(wip), .done(done), .wel_clr(wel_clr)
    );

    pgw_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .clear(lat_clear), .wr_en(lat_wr), .wr_slot(lat_slot), .wr_data(byte_data),
        .rd_slot(rd_slot), .rd_data(lat_rd_data), .rd_valid(lat_rd_valid),
        .any_valid(any_valid)
    );

    pgw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expire(tmr_expire)
    );

    pgw_mem_array #(.ADDR_W(ADDR_W), .ERASED(8'hFF)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .wr_addr(mem_addr), .wr_data(lat_rd_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial begin
        assert_page_pow2_R3: assert ((1 << OFS_W) == PAGE_BYTES && OFS_W < ADDR_W)
            else $error("PAGE_BYTES must be a power of two below the address space");
    end
endmodule

// File: tb/sim_page_prog_seq.sv
`timescale 1ns/10ps
module sim_page_prog_seq;
    localparam int AW   = 10;
    localparam int PAGE = 64;
    localparam int PROG = 40;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, wel = 1'b0, permit = 1'b0, byte_vld = 1'b0;
    logic cs_rise = 1'b0, pwr_fail = 1'b0;
    logic [AW-1:0] start_addr = '0, rd_addr = '0;
    logic [7:0] byte_data = '0, rd_data;
    logic [2:0] bit_phase = '0;
    logic wip, done, wel_clr;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] fbuf [128];

    always #2.5 clk = ~clk;

    page_prog_seq #(.PAGE_BYTES(PAGE), .ADDR_W(AW), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .wel(wel), .permit(permit), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .bit_phase(bit_phase), .pwr_fail(pwr_fail),
        .rd_addr(rd_addr), .rd_data(rd_data), .wip(wip), .done(done), .wel_clr(wel_clr)
    );

    function automatic int target(int base, int k);
        return (base & ~(PAGE - 1)) | ((base + k) & (PAGE - 1));
    endfunction

    function automatic bit will_program(bit w, bit p, int phase, int len);
        return w && p && phase == 0 && len > 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check_mem(string tag);
        int bad = 0;
        n_chk++;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            if (rd_data !== exp_mem[a]) begin
                if (bad == 0)
                    $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, rd_data, exp_mem[a]);
                bad++;
            end
        end
        if (bad != 0) n_fail++;
    endtask

    task automatic send_frame(int addr, int len, bit w, bit p, int phase);
        tick();
        cmd_start = 1'b1; start_addr = AW'(addr); wel = w; permit = p;
        tick();
        cmd_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            byte_vld = 1'b1; byte_data = fbuf[i];
            tick();
            byte_vld = 1'b0;
            tick();
        end
        cs_rise = 1'b1; bit_phase = 3'(phase);
        tick();
        cs_rise = 1'b0; bit_phase = 3'd0;
    endtask

    task automatic wait_idle(output int hi, output int dn, output bit pulse_ok);
        hi = 0; dn = 0; pulse_ok = 1'b1;
        for (int c = 0; c < PROG + PAGE + 20; c++) begin
            @(negedge clk);
            if (wip) hi++;
            if (done) begin
                dn++;
                if (!wel_clr || !wip) pulse_ok = 1'b0;
            end
        end
    endtask

    task automatic expect_quiet(string tag);
        int hi = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (wip) hi++;
        end
        chk(hi == 0, tag, hi, 0);
    endtask

    task automatic run_frame(int addr, int len, bit w, bit p, int phase, string tag);
        int hi, dn;
        bit pok;
        send_frame(addr, len, w, p, phase);
        if (will_program(w, p, phase, len)) begin
            wait_idle(hi, dn, pok);
            chk(hi == PROG + PAGE, {"R6 wip length ", tag}, hi, PROG + PAGE);
            chk(dn == 1 && pok, {"R8 done pulse ", tag}, dn, 1);
            for (int k = 0; k < len; k++) exp_mem[target(addr, k)] = fbuf[k];
        end else begin
            expect_quiet({"R2/R5 no program ", tag});
        end
        check_mem({"R3 R4 R7 memory ", tag});
    endtask

    initial begin
        #900000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, dn;
        bit pok;
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(!wip && !done && !wel_clr, "R1 outputs after reset", {wip, done, wel_clr}, 0);
        check_mem("R1 erased memory");

        // R3: mid-page start wraps to offset 0
        for (int i = 0; i < 10; i++) fbuf[i] = 8'(8'h30 + i);
        run_frame(64 * 3 + 60, 10, 1, 1, 0, "wrap inside page");

        // R4: 70 bytes, last six overwrite
        for (int i = 0; i < 70; i++) fbuf[i] = 8'(i * 3 + 1);
        run_frame(64 * 5 + 2, 70, 1, 1, 0, "R4 overlong page");

        // R2: rejections
        for (int i = 0; i < 4; i++) fbuf[i] = 8'hA5;
        run_frame(64 * 7, 4, 0, 1, 0, "R2 wel low");
        run_frame(64 * 7, 4, 1, 0, 0, "R2 permit low");

        // R5: bad closes
        run_frame(64 * 8, 4, 1, 1, 3, "R5 partial byte");
        run_frame(64 * 8, 0, 1, 1, 0, "R5 no data");

        // R2: command during a running cycle is ignored
        for (int i = 0; i < 3; i++) fbuf[i] = 8'(8'h70 + i);
        send_frame(64 * 9, 3, 1, 1, 0);
        for (int k = 0; k < 3; k++) exp_mem[target(64 * 9, k)] = fbuf[k];
        for (int i = 0; i < 3; i++) fbuf[i] = 8'hEE;
        send_frame(64 * 10, 3, 1, 1, 0);
        wait_idle(hi, dn, pok);
        chk(dn == 1, "R2 busy frame ignored done count", dn, 1);
        check_mem("R2 busy frame ignored memory");

        // R9: supply failure during the timer
        for (int i = 0; i < 5; i++) fbuf[i] = 8'h11;
        send_frame(64 * 11, 5, 1, 1, 0);
        repeat (10) tick();
        pwr_fail = 1'b1;
        @(negedge clk);
        chk(wel_clr == 1'b1, "R9 wel_clr with pwr_fail", wel_clr, 1);
        tick();
        pwr_fail = 1'b0;
        @(negedge clk);
        chk(wip == 1'b0, "R9 wip low after abort", wip, 0);
        expect_quiet("R9 stays idle");
        check_mem("R9 aborted page unchanged");

        // R9: supply failure while collecting, then a clean close
        tick();
        cmd_start = 1'b1; start_addr = AW'(64 * 12); wel = 1'b1; permit = 1'b1;
        tick();
        cmd_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h5A;
        tick();
        byte_vld = 1'b0; pwr_fail = 1'b1;
        tick();
        pwr_fail = 1'b0; cs_rise = 1'b1;
        tick();
        cs_rise = 1'b0;
        expect_quiet("R9 abort while collecting");
        check_mem("R9 collect abort memory");

        // constrained random frames
        for (int f = 0; f < 22; f++) begin
            int addr, len, phase;
            bit w, p;
            addr = int'($urandom % DEPTH);
            len = 1 + int'($urandom % 80);
            w = ($urandom % 8) != 0;
            p = ($urandom % 8) != 0;
            phase = (($urandom % 6) == 0) ? 1 + int'($urandom % 7) : 0;
            for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
            run_frame(addr, len, w, p, phase, $sformatf("random %0d", f));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule